// File: doc/BRIEF.md
# Lockable Analog Trim Register Bank

This block holds the trim codes that tune on-chip analog circuits. Firmware loads the codes after power-up through a simple byte-wide register bus. The bank drives the codes, with their enable flags, straight to the analog side as output ports. The bank has four 8-bit registers. Either of two address windows reaches them. The windows differ only in the bus timing the fabric applies, so both land on the same storage.

The register at the bottom of the bank carries the sleep-reference trim, which firmware sets in two phases. While the field is unlocked, firmware writes trial codes with the field enable set and the lock bit clear, until the reference is right. A single write then carries the final code, the enable and the lock together. From that point the code, the enable and the lock stay frozen until the next reset. The registers keep their contents through low-power mode, and only reset returns them to zero.

Top module: `trim_bank`

## Requirements
- R1: After reset, every register reads 0x00 and every trim output, enable and the lock output are 0.
- R2: Bus addresses 0x2F0–0x2F3 and 0x3F0–0x3F3 alias the same four registers, at index = address[1:0]. A write through either window reads back through the other.
- R3: A read strobe (bus_sel=1, bus_wr=0) to a mapped address gives rd_valid=1 and the register content on rd_data in the next cycle. An access to any other address sets no rd_valid and changes no register.
- R4: The register at 0xF0 has this layout: bits[2:0] sleep-reference code, bit 3 lock, bit 4 sleep-reference enable, bits[7:5] bias code. Each field appears on its own output one cycle after the write.
- R5: While the lock is 0, a write to 0xF0 with bit 3 clear stores all eight bits as written.
- R6: While the lock is 0, a write to 0xF0 with bit 3 set stores the code, the enable and the lock from that same write in one cycle.
- R7: While the lock is 1, writes to 0xF0 leave bits[4:0] unchanged, and bits[7:5] still take the written value.
- R8: A locking write with the enable bit clear still locks. The code it carries is frozen and the enable stays 0.
- R9: Only reset clears the lock. After reset the sleep-reference field can be adjusted again.
- R10: The register at 0xF2 stores and reads back any byte and drives no output.
- R11: The low_power input has no effect on register contents. Contents persist while it is high, and writes still land.
- R12: The register at 0xF1 drives aux_code from bits[6:0] and aux_en from bit 7. The register at 0xF3 drives cur_ref_code from bits[2:0] and cur_ref_en from bit 3. Bits[7:4] of 0xF3 are stored and read back only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_power | input | 1 | Low-power mode indication (retention) |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a mapped read |
| rd_data | output | 8 | Read data |
| sleep_ref_code | output | 3 | Sleep-reference trim code |
| sleep_ref_en | output | 1 | Sleep-reference trim enable |
| sleep_ref_locked | output | 1 | Sleep-reference trim lock state |
| bias_code | output | 3 | Bias trim code |
| aux_code | output | 7 | Auxiliary trim code |
| aux_en | output | 1 | Auxiliary trim enable |
| cur_ref_code | output | 3 | Current-reference trim code |
| cur_ref_en | output | 1 | Current-reference trim enable |

## Verification
The hardest state to reach is a locked field that then receives every possible byte. The bench must also show that only the upper three bits move, and that only a reset undoes the lock. The stimulus first sweeps all unlocked adjust values. It then commits one code and sweeps all 256 bytes into the locked register through alternating windows, checking read-back and outputs after each write. After a reset it repeats the commit with the enable clear, to cover the lock-without-enable case.

// File: rtl/trim_bank_pkg.sv
package trim_bank_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 4;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam int SLEEP_IDX = 0;
    localparam int AUX_IDX   = 1;
    localparam int RSV_IDX   = 2;
    localparam int CUR_IDX   = 3;

    typedef struct packed {
        logic [2:0] bias;
        logic       en;
        logic       lock;
        logic [2:0] code;
    } sleep_reg_t;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] data;
    } rd_state_t;
endpackage

// File: rtl/trim_addr_dec.sv
module trim_addr_dec #(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 4,
    parameter int WIN_A    = 'h2,
    parameter int WIN_B    = 'h3,
    parameter int OFFSET   = 'hF0
) (
    input  logic [ADDR_W-1:0]           addr,
    output logic                        hit,
    output logic [$clog2(NUM_REGS)-1:0] idx,
    output logic [NUM_REGS-1:0]         reg_sel
);
    localparam int IW    = $clog2(NUM_REGS);
    localparam int WIN_W = ADDR_W - 8;

    logic win_ok;
    logic off_ok;

    always_comb begin
        win_ok  = (addr[ADDR_W-1:8] == WIN_W'(WIN_A)) ||
                  (addr[ADDR_W-1:8] == WIN_W'(WIN_B));
        off_ok  = (addr[7:IW] == (8-IW)'(OFFSET >> IW));
        hit     = win_ok && off_ok;
        idx     = addr[IW-1:0];
        reg_sel = '0;
        if (hit) reg_sel[idx] = 1'b1;
    end

    // R2: at most one register selected per access
    always_comb begin
        assert_sel_onehot_R2: assert ($onehot0(reg_sel));
    end
endmodule

// File: rtl/trim_plain_reg.sv
module trim_plain_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } plain_t;

    plain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.val = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/trim_lock_reg.sv
module trim_lock_reg
    import trim_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    sleep_reg_t st_d, st_q;
    sleep_reg_t wfield;

    always_comb begin
        wfield = sleep_reg_t'(wdata);
        st_d   = st_q;
        if (wr_en) begin
            st_d.bias = wfield.bias;
            if (!st_q.lock) begin
                st_d.code = wfield.code;
                st_d.en   = wfield.en;
                st_d.lock = wfield.lock;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q;

    // R7: once locked, lock stays set and the guarded fields hold
    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock);
    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> ($stable(st_q.code) && $stable(st_q.en)));
    // R6: a committing write while unlocked takes effect in one cycle
    assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !st_q.lock && wdata[3]) |=> (st_q.lock && st_q.code == $past(wdata[2:0])));
endmodule

// File: rtl/trim_bank.sv
module trim_bank
    import trim_bank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WIN_A  = 'h2,
    parameter int WIN_B  = 'h3,
    parameter int OFFSET = 'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_power,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic              rd_valid,
    output logic [REG_W-1:0]  rd_data,
    output logic [2:0]        sleep_ref_code,
    output logic              sleep_ref_en,
    output logic              sleep_ref_locked,
    output logic [2:0]        bias_code,
    output logic [6:0]        aux_code,
    output logic              aux_en,
    output logic [2:0]        cur_ref_code,
    output logic              cur_ref_en
);
    logic                              hit;
    logic [IDX_W-1:0]                  idx;
    logic [NUM_REGS-1:0]               reg_sel;
    logic [NUM_REGS-1:0][REG_W-1:0]    reg_q;
    logic                              wr_go;
    logic                              rd_go;
    rd_state_t                         rd_d, rd_q;

    trim_addr_dec #(
        .ADDR_W  (ADDR_W),
        .NUM_REGS(NUM_REGS),
        .WIN_A   (WIN_A),
        .WIN_B   (WIN_B),
        .OFFSET  (OFFSET)
    ) u_dec (
        .addr   (bus_addr),
        .hit    (hit),
        .idx    (idx),
        .reg_sel(reg_sel)
    );

    assign wr_go = bus_sel && bus_wr;
    assign rd_go = bus_sel && !bus_wr && hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == SLEEP_IDX) begin : g_lock
            trim_lock_reg u_reg (
                .clk  (clk),
                .rst_n(rst_n),
                .wr_en(wr_go && reg_sel[i]),
                .wdata(bus_wdata),
                .q    (reg_q[i])
            );
        end else begin : g_plain
            trim_plain_reg #(.W(REG_W)) u_reg (
                .clk  (clk),
                .rst_n(rst_n),
                .wr_en(wr_go && reg_sel[i]),
                .wdata(bus_wdata),
                .q    (reg_q[i])
            );
        end
    end

    always_comb begin
        rd_d       = '0;
        rd_d.valid = rd_go;
        if (rd_go) rd_d.data = reg_q[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    assign sleep_ref_code   = reg_q[SLEEP_IDX][2:0];
    assign sleep_ref_locked = reg_q[SLEEP_IDX][3];
    assign sleep_ref_en     = reg_q[SLEEP_IDX][4];
    assign bias_code        = reg_q[SLEEP_IDX][7:5];
    assign aux_code         = reg_q[AUX_IDX][6:0];
    assign aux_en           = reg_q[AUX_IDX][7];
    assign cur_ref_code     = reg_q[CUR_IDX][2:0];
    assign cur_ref_en       = reg_q[CUR_IDX][3];

    // R3: read data valid exactly one cycle after a mapped read
    assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> rd_valid);
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !rd_valid);
    assert_read_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !wr_go) |=> (rd_data == $past(reg_q[idx])));
    // R11: low-power mode without writes keeps every register unchanged
    assert_retain_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && !wr_go) |=> $stable(reg_q));
endmodule

// File: tb/trim_bank_tb.sv
`timescale 1ns/1ps
module trim_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        low_power = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [2:0]  sleep_ref_code;
    logic        sleep_ref_en;
    logic        sleep_ref_locked;
    logic [2:0]  bias_code;
    logic [6:0]  aux_code;
    logic        aux_en;
    logic [2:0]  cur_ref_code;
    logic        cur_ref_en;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [4];

    always #4 clk = ~clk;

    trim_bank u_dut (
        .clk(clk), .rst_n(rst_n), .low_power(low_power),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .sleep_ref_code(sleep_ref_code), .sleep_ref_en(sleep_ref_en),
        .sleep_ref_locked(sleep_ref_locked), .bias_code(bias_code),
        .aux_code(aux_code), .aux_en(aux_en),
        .cur_ref_code(cur_ref_code), .cur_ref_en(cur_ref_en)
    );

    function automatic logic [11:0] map_addr(input int win, input int idx);
        return {(win != 0) ? 4'h3 : 4'h2, 8'hF0 + 8'(idx)};
    endfunction

    function automatic logic [7:0] next_sleep(input logic [7:0] old, input logic [7:0] w);
        if (old[3]) return {w[7:5], old[4:0]};
        return w;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        check(32'(sleep_ref_code),   32'(model[0][2:0]), {tag, " R4 code"});
        check(32'(sleep_ref_locked), 32'(model[0][3]),   {tag, " R4 lock"});
        check(32'(sleep_ref_en),     32'(model[0][4]),   {tag, " R4 en"});
        check(32'(bias_code),        32'(model[0][7:5]), {tag, " R4 bias"});
        check(32'(aux_code),         32'(model[1][6:0]), {tag, " R12 aux code"});
        check(32'(aux_en),           32'(model[1][7]),   {tag, " R12 aux en"});
        check(32'(cur_ref_code),     32'(model[3][2:0]), {tag, " R12 cur code"});
        check(32'(cur_ref_en),       32'(model[3][3]),   {tag, " R12 cur en"});
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic v_exp,
                           input logic [7:0] d_exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check(32'(rd_valid), 32'(v_exp), {tag, " valid"});
        if (v_exp) check(32'(rd_data), 32'(d_exp), {tag, " data"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) model[i] = 8'h00;
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 4; i++) do_read(map_addr(i % 2, i), 1'b1, model[i], tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_outs("R1 reset");
        check(32'(rd_valid), 0, "R1 rd_valid");
        rst_n = 1'b1;
        read_all("R1 readback");

        // R2 R10 R12: sweep plain registers through alternating windows
        for (int r = 1; r < 4; r++) begin
            for (int v = 0; v < 256; v++) begin
                do_write(map_addr(v % 2, r), 8'(v));
                model[r] = 8'(v);
                check_outs(r == 2 ? "R10 reserved" : "R12 plain");
                do_read(map_addr((v + 1) % 2, r), 1'b1, model[r], "R2 alias");
            end
        end

        // R5: unlocked adjust sweep
        for (int v = 0; v < 256; v++) begin
            if (v[3] == 1'b0) begin
                do_write(map_addr(v % 2, 0), 8'(v));
                model[0] = next_sleep(model[0], 8'(v));
                check_outs("R5 adjust");
                do_read(map_addr((v + 1) % 2, 0), 1'b1, model[0], "R5 readback");
            end
        end

        // R3: unmapped addresses
        do_write(12'h1F0, 8'hFF);
        do_write(12'h2EF, 8'hFF);
        do_write(12'h2F4, 8'hFF);
        do_write(12'h3F7, 8'hFF);
        do_write(12'h0F0, 8'hFF);
        do_write(12'hAF1, 8'hFF);
        check_outs("R3 miss write");
        do_read(12'h2F4, 1'b0, 8'h00, "R3 miss read");
        do_read(12'h4F0, 1'b0, 8'h00, "R3 miss read");
        read_all("R3 after misses");

        // R11: low power retention, writes still land
        low_power = 1'b1;
        repeat (20) @(negedge clk);
        read_all("R11 retain");
        do_write(map_addr(1, 3), 8'h5A);
        model[3] = 8'h5A;
        check_outs("R11 write in low power");
        do_read(map_addr(0, 3), 1'b1, 8'h5A, "R11 readback");
        low_power = 1'b0;

        // R6: commit code 5, enable, lock, bias 5
        do_write(map_addr(0, 0), 8'hBD);
        model[0] = 8'hBD;
        check(32'(sleep_ref_locked), 1, "R6 locked");
        check(32'(sleep_ref_code), 5, "R6 code");
        check(32'(sleep_ref_en), 1, "R6 en");

        // R7: all bytes into locked register
        for (int v = 0; v < 256; v++) begin
            do_write(map_addr(v % 2, 0), 8'(v));
            model[0] = next_sleep(model[0], 8'(v));
            check_outs("R7 locked sweep");
            do_read(map_addr((v + 1) % 2, 0), 1'b1, model[0], "R7 readback");
        end
        check(32'(model[0][4:0]), 32'h1D, "R7 model sanity");

        // R9: reset clears lock, adjust possible again
        do_reset();
        check_outs("R9 after reset");
        read_all("R1 after reset");
        do_write(map_addr(1, 0), 8'h16);
        model[0] = 8'h16;
        check(32'(sleep_ref_code), 6, "R9 adjust after reset");
        check(32'(sleep_ref_locked), 0, "R9 unlocked");

        // R8: lock with enable clear
        do_write(map_addr(0, 0), 8'h0B);
        model[0] = 8'h0B;
        check(32'(sleep_ref_locked), 1, "R8 locked");
        check(32'(sleep_ref_en), 0, "R8 en clear");
        check(32'(sleep_ref_code), 3, "R8 code");
        do_write(map_addr(1, 0), 8'hF7);
        model[0] = next_sleep(model[0], 8'hF7);
        check_outs("R8 ignored write");
        do_read(map_addr(0, 0), 1'b1, 8'hEB, "R8 readback");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule